// File: doc/BRIEF.md
# Programmable Chip-Select and Strobe Generator

This block turns a simple bus cycle into memory chip-selects and read/write strobes. Software loads eight address regions through a register write port. Each region has a base, a power-of-two size with 64 KB granularity, a data width, and separate read and write enables. Each region also has a timing word that sets four values, all counted in clocks from the start of the cycle: when the strobe asserts, when it deasserts, when READY is returned, and how long a recovery gap runs before the same region may be accessed again.

Eight active-low strobe pins are each bound to one region. A pin is qualified by the access direction and can optionally compare address bits 15:8 under a mask. A pin works either as a plain chip-select that stays low for the whole access, or as a timed strobe that follows the region's assert and deassert offsets. If several regions match, the lowest-numbered enabled region is used. An access that matches no region gets READY after a fixed default delay and drives no strobe.

A single controller runs one access at a time through four named states:
- **IDLE → ACTIVE** on a start pulse.
- **ACTIVE → RECOVER** at READY when the region's gap is non-zero. **ACTIVE → IDLE** at READY when the gap is zero.
- **RECOVER → IDLE** when the gap counter expires.
- **RECOVER → ACTIVE** on a start to any other region, or on a start to the same region in the last gap cycle.
- **RECOVER → STALL** on an earlier start to the same region.
- **STALL → ACTIVE** when the gap expires.

Top module: `csg_strobe_gen`

## Requirements
- R1: After reset every strobe is high, READY is low, the width output is 0, and all configuration is zero. This means every access is unmatched.
- R2: A configuration write takes effect at the clock edge where `cfg_we` is high. `cfg_addr[4:3]` selects the bank: 0 for region decode, 1 for region timing, 2 for pin configuration. `cfg_addr[2:0]` selects the entry.
  - Decode word: base = bits 31:16, size code = 15:12, width = 11:10, read enable = 9, write enable = 8.
  - Timing word: assert offset = 7:0, deassert offset = 15:8, READY delay = 23:16, recovery gap = 31:24.
  - Pin word: region = 2:0, access = 4:3, timed mode = 5, sub-decode enable = 6, sub-decode mask = 15:8, sub-decode value = 23:16.
- R3: A region matches when address bits 31:16 equal its base, ignoring the low k bits, where k is the size code (so the region covers 2^k × 64 KB). The region must also be enabled for the access direction.
- R4: When several regions match, the lowest-numbered one is selected.
- R5: If a start is sampled at edge n and the access begins at once, READY is high for exactly the one cycle that follows edge n+d, where d is the region's READY delay.
- R6: An unmatched access returns READY with d = 2 (the default). It drives no strobe and outputs a width of 0.
- R7: A pin in chip-select mode (timed bit 0) is low for every cycle of its region's access, from the cycle after the start through the READY cycle.
- R8: A pin in timed mode is low in the cycle that follows edge n+k when assert ≤ k < deassert and k ≤ d. It is never low when deassert ≤ assert.
- R9: Access code 01 allows reads only, 10 allows writes only, 11 allows both, and 00 allows neither. A pin whose code does not allow the direction stays high.
- R10: With sub-decode enabled, a pin drives only when (addr[15:8] XOR value) AND mask is zero.
- R11: After an access to a region with gap g > 0 whose READY cycle is R, a start to the same region before cycle R+g+1 has its first access cycle at R+g+1. Strobes and READY stay quiet until then. A start to a different region during the gap proceeds at once.
- R12: During an access to a matched region, `data_width` shows that region's width field. Outside accesses it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Bank select (bits 4:3) and entry index (bits 2:0) |
| cfg_wdata | input | 32 | Configuration write data |
| cyc_start | input | 1 | One-cycle bus cycle start pulse |
| cyc_addr | input | 24 | Bus address bits 31:8 |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| strobe_n | output | 8 | Active-low chip-select / strobe pins |
| ready | output | 1 | One-cycle cycle-complete indication |
| data_width | output | 2 | Data width of the selected region |

## Verification
The bench targets overlapping regions, where a design with the priority reversed would drive the higher-numbered region's pins. It also targets the edges of a power-of-two size, where an off-by-one mask would take in or drop the neighbouring 64 KB block. Timed windows are tested as empty, clipped by READY, and starting at offset 0. A wrong comparison there would leave a strobe low one cycle too long, or assert it when it should not assert at all. Recovery is exercised with same-region starts early in the gap, in its last cycle, and after it, plus a start to another region during the gap. Getting the gap wrong would show up as READY one cycle early or late, or as an unrelated access being held back.

// File: rtl/csg_pkg.sv
package csg_pkg;
    localparam int NREG = 8;
    localparam int NPIN = 8;
    localparam int TW   = 8;
    localparam int AW   = 32;
    localparam int IW   = $clog2(NREG);
    localparam int CAW  = IW + 2;
    localparam int HIW  = AW - 16;
    localparam int LAW  = AW - 8;

    typedef struct packed {
        logic [HIW-1:0] base;
        logic [3:0]     size;
        logic [1:0]     width;
        logic           rd_en;
        logic           wr_en;
    } region_t;

    typedef struct packed {
        logic [TW-1:0] b2b;
        logic [TW-1:0] rdy;
        logic [TW-1:0] deas;
        logic [TW-1:0] asrt;
    } timing_t;

    typedef struct packed {
        logic [7:0]    sub_val;
        logic [7:0]    sub_mask;
        logic          sub_en;
        logic          sync;
        logic [1:0]    access;
        logic [IW-1:0] region;
    } pin_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_RECOVER,
        ST_STALL
    } state_t;
endpackage

// File: rtl/csg_cfg_regs.sv
module csg_cfg_regs
    import csg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CAW-1:0]       addr,
    input  logic [31:0]          wdata,
    output region_t [NREG-1:0]   regions,
    output timing_t [NREG-1:0]   timings,
    output pin_t    [NPIN-1:0]   pins
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regions <= '0;
            timings <= '0;
            pins    <= '0;
        end else if (we) begin
            unique case (addr[CAW-1:IW])
                2'd0: begin
                    regions[addr[IW-1:0]].base  <= wdata[31:16];
                    regions[addr[IW-1:0]].size  <= wdata[15:12];
                    regions[addr[IW-1:0]].width <= wdata[11:10];
                    regions[addr[IW-1:0]].rd_en <= wdata[9];
                    regions[addr[IW-1:0]].wr_en <= wdata[8];
                end
                2'd1: begin
                    timings[addr[IW-1:0]].asrt <= wdata[TW-1:0];
                    timings[addr[IW-1:0]].deas <= wdata[2*TW-1:TW];
                    timings[addr[IW-1:0]].rdy  <= wdata[3*TW-1:2*TW];
                    timings[addr[IW-1:0]].b2b  <= wdata[4*TW-1:3*TW];
                end
                2'd2: begin
                    pins[addr[IW-1:0]].region   <= wdata[IW-1:0];
                    pins[addr[IW-1:0]].access   <= wdata[4:3];
                    pins[addr[IW-1:0]].sync     <= wdata[5];
                    pins[addr[IW-1:0]].sub_en   <= wdata[6];
                    pins[addr[IW-1:0]].sub_mask <= wdata[15:8];
                    pins[addr[IW-1:0]].sub_val  <= wdata[23:16];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csg_region_match.sv
module csg_region_match
    import csg_pkg::*;
(
    input  region_t [NREG-1:0] regions,
    input  logic [HIW-1:0]     addr_hi,
    input  logic               write,
    output logic               valid,
    output logic [IW-1:0]      idx
);
    logic [NREG-1:0] cand;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [HIW-1:0] ign;
        assign ign     = ~({HIW{1'b1}} << regions[i].size);
        assign cand[i] = (write ? regions[i].wr_en : regions[i].rd_en)
                         && (((addr_hi ^ regions[i].base) & ~ign) == '0);
    end

    always_comb begin
        valid = |cand;
        idx   = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/csg_pin_gen.sv
module csg_pin_gen
    import csg_pkg::*;
(
    input  pin_t [NPIN-1:0] pins,
    input  logic            active,
    input  logic            hit_vld,
    input  logic [IW-1:0]   hit_idx,
    input  logic            write,
    input  logic [7:0]      sub_addr,
    input  logic [TW-1:0]   cnt,
    input  logic [TW-1:0]   asrt,
    input  logic [TW-1:0]   deas,
    output logic [NPIN-1:0] strobe_n
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic acc_ok, sub_ok, win_ok, low;
        always_comb begin
            acc_ok = write ? pins[p].access[1] : pins[p].access[0];
            sub_ok = !pins[p].sub_en
                     || (((sub_addr ^ pins[p].sub_val) & pins[p].sub_mask) == 8'h00);
            win_ok = !pins[p].sync || ((cnt >= asrt) && (cnt < deas));
            low    = active && hit_vld && (pins[p].region == hit_idx)
                     && acc_ok && sub_ok && win_ok;
        end
        assign strobe_n[p] = ~low;
    end
endmodule

// File: rtl/csg_strobe_gen.sv
module csg_strobe_gen
    import csg_pkg::*;
#(
    parameter int DFLT_RDY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CAW-1:0]   cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             cyc_start,
    input  logic [LAW-1:0]   cyc_addr,
    input  logic             cyc_write,
    output logic [NPIN-1:0]  strobe_n,
    output logic             ready,
    output logic [1:0]       data_width
);
    region_t [NREG-1:0] regions;
    timing_t [NREG-1:0] timings;
    pin_t    [NPIN-1:0] pins;

    state_t           state_q, state_d;
    logic [TW-1:0]    cnt_q, cnt_d, gcnt_q, gcnt_d;
    logic [LAW-1:0]   cur_a_q, cur_a_d;
    logic             cur_wr_q, cur_wr_d;
    logic [IW-1:0]    rec_q, rec_d;

    logic             in_vld, cur_vld;
    logic [IW-1:0]    in_idx, cur_idx;
    timing_t          tim_cur;
    logic [TW-1:0]    rdy_eff, b2b_eff;
    logic             active;

    csg_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .regions (regions),
        .timings (timings),
        .pins    (pins)
    );

    csg_region_match u_dec_in (
        .regions (regions),
        .addr_hi (cyc_addr[LAW-1:8]),
        .write   (cyc_write),
        .valid   (in_vld),
        .idx     (in_idx)
    );

    csg_region_match u_dec_cur (
        .regions (regions),
        .addr_hi (cur_a_q[LAW-1:8]),
        .write   (cur_wr_q),
        .valid   (cur_vld),
        .idx     (cur_idx)
    );

    assign tim_cur = timings[cur_idx];
    assign rdy_eff = cur_vld ? tim_cur.rdy : TW'(DFLT_RDY);
    assign b2b_eff = cur_vld ? tim_cur.b2b : '0;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            gcnt_q   <= '0;
            cur_a_q  <= '0;
            cur_wr_q <= 1'b0;
            rec_q    <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            gcnt_q   <= gcnt_d;
            cur_a_q  <= cur_a_d;
            cur_wr_q <= cur_wr_d;
            rec_q    <= rec_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        gcnt_d   = gcnt_q;
        cur_a_d  = cur_a_q;
        cur_wr_d = cur_wr_q;
        rec_d    = rec_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_start) begin
                    cur_a_d  = cyc_addr;
                    cur_wr_d = cyc_write;
                    cnt_d    = '0;
                    state_d  = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (cnt_q == rdy_eff) begin
                    if (b2b_eff != '0) begin
                        state_d = ST_RECOVER;
                        gcnt_d  = b2b_eff;
                        rec_d   = cur_idx;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + TW'(1);
                end
            end
            ST_RECOVER: begin
                if (cyc_start) begin
                    cur_a_d  = cyc_addr;
                    cur_wr_d = cyc_write;
                    cnt_d    = '0;
                    if (in_vld && (in_idx == rec_q) && (gcnt_q != TW'(1))) begin
                        state_d = ST_STALL;
                        gcnt_d  = gcnt_q - TW'(1);
                    end else begin
                        state_d = ST_ACTIVE;
                    end
                end else if (gcnt_q == TW'(1)) begin
                    state_d = ST_IDLE;
                end else begin
                    gcnt_d = gcnt_q - TW'(1);
                end
            end
            ST_STALL: begin
                if (gcnt_q == TW'(1)) begin
                    state_d = ST_ACTIVE;
                    cnt_d   = '0;
                end else begin
                    gcnt_d = gcnt_q - TW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        active     = (state_q == ST_ACTIVE);
        ready      = active && (cnt_q == rdy_eff);
        data_width = (active && cur_vld) ? regions[cur_idx].width : 2'b00;
    end

    csg_pin_gen u_pins (
        .pins     (pins),
        .active   (active),
        .hit_vld  (cur_vld),
        .hit_idx  (cur_idx),
        .write    (cur_wr_q),
        .sub_addr (cur_a_q[7:0]),
        .cnt      (cnt_q),
        .asrt     (tim_cur.asrt),
        .deas     (tim_cur.deas),
        .strobe_n (strobe_n)
    );

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R5
    AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACTIVE) |-> (strobe_n == '1 && !ready && data_width == 2'b00)); // R11
    AST_UNMATCHED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !cur_vld) |-> (strobe_n == '1 && data_width == 2'b00)); // R6
    AST_STALL_SAME_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> (cur_vld && cur_idx == rec_q)); // R11
    AST_GAP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && !cyc_start && gcnt_q > TW'(1))
        |=> (state_q == ST_RECOVER && gcnt_q == $past(gcnt_q) - TW'(1))); // R11
endmodule

// File: tb/csg_strobe_gen_test.sv
`timescale 1ns/1ps
module csg_strobe_gen_test;
    localparam int DFLT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic [23:0] cyc_addr = '0;
    logic        cyc_write = 1'b0;
    logic [7:0]  strobe_n;
    logic        ready;
    logic [1:0]  data_width;

    int n_vec = 0;
    int n_fail = 0;
    int ncyc = 0;
    bit done = 0;
    logic [31:0] sh_dec [8];
    logic [31:0] sh_tim [8];
    logic [31:0] sh_pin [8];
    int last_R = -100;
    int last_idx = -1;
    int last_b2b = 0;

    always #2 clk = ~clk;

    csg_strobe_gen #(.DFLT_RDY(DFLT)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cyc_start  (cyc_start),
        .cyc_addr   (cyc_addr),
        .cyc_write  (cyc_write),
        .strobe_n   (strobe_n),
        .ready      (ready),
        .data_width (data_width)
    );

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        ncyc++;
    endtask

    task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, ncyc);
        end
    endtask

    function automatic logic [31:0] mk_dec(logic [15:0] base, logic [3:0] size,
                                           logic [1:0] w, logic rd, logic wr);
        return {base, size, w, rd, wr, 8'h00};
    endfunction

    function automatic logic [31:0] mk_tim(logic [7:0] as, logic [7:0] de,
                                           logic [7:0] rd, logic [7:0] gap);
        return {gap, rd, de, as};
    endfunction

    function automatic logic [31:0] mk_pin(logic [2:0] rg, logic [1:0] acc, logic sy,
                                           logic se, logic [7:0] msk, logic [7:0] val);
        return {8'h00, val, msk, 1'b0, se, sy, acc, rg};
    endfunction

    task automatic wr_cfg(int sel, int idx, logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = {sel[1:0], idx[2:0]};
        cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
        if (sel == 0) sh_dec[idx] = d;
        else if (sel == 1) sh_tim[idx] = d;
        else sh_pin[idx] = d;
    endtask

    function automatic int exp_idx(logic [23:0] a, logic w);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] ign;
            ign = ~(16'hFFFF << sh_dec[i][15:12]);
            if ((w ? sh_dec[i][8] : sh_dec[i][9])
                && (((a[23:8] ^ sh_dec[i][31:16]) & ~ign) == 16'h0))
                return i;
        end
        return -1;
    endfunction

    function automatic logic [7:0] exp_strobe(int idx, logic [23:0] a, logic w, int k);
        logic [7:0] s;
        s = 8'hFF;
        if (idx < 0) return s;
        for (int p = 0; p < 8; p++) begin
            logic [31:0] pc;
            logic acc_ok, sub_ok, win_ok;
            int as_v, de_v;
            pc = sh_pin[p];
            as_v = int'(sh_tim[idx][7:0]);
            de_v = int'(sh_tim[idx][15:8]);
            acc_ok = w ? pc[4] : pc[3];
            sub_ok = !pc[6] || (((a[7:0] ^ pc[23:16]) & pc[15:8]) == 8'h00);
            win_ok = !pc[5] || (k >= as_v && k < de_v);
            if (int'(pc[2:0]) == idx && acc_ok && sub_ok && win_ok) s[p] = 1'b0;
        end
        return s;
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            tick();
            chk({7'b0, ready}, 8'h00, "R11 gap ready");
            chk(strobe_n, 8'hFF, "R11 gap strobes");
        end
    endtask

    task automatic txn(logic [23:0] a, logic w, string tag);
        int idx, rdy, A, N, k;
        logic [7:0] exp_w;
        idx = exp_idx(a, w);
        rdy = (idx >= 0) ? int'(sh_tim[idx][23:16]) : DFLT;
        N = ncyc;
        A = N + 1;
        if (idx >= 0 && idx == last_idx && last_b2b > 0 && N <= last_R + last_b2b)
            A = last_R + last_b2b + 1;
        exp_w = (idx >= 0) ? {6'b0, sh_dec[idx][11:10]} : 8'h00;
        cyc_start = 1'b1;
        cyc_addr = a;
        cyc_write = w;
        tick();
        cyc_start = 1'b0;
        forever begin
            k = ncyc - A;
            if (k < 0) begin
                chk({7'b0, ready}, 8'h00, {tag, " R11 stalled ready"});
                chk(strobe_n, 8'hFF, {tag, " R11 stalled strobes"});
            end else begin
                chk(strobe_n, exp_strobe(idx, a, w, k), {tag, " strobes R7 R8"});
                chk({7'b0, ready}, {7'b0, (k == rdy)}, {tag, (idx < 0) ? " R6 ready" : " R5 ready"});
                chk({6'b0, data_width}, exp_w, {tag, " R12 width"});
            end
            if (k >= rdy) break;
            tick();
        end
        last_R = ncyc;
        last_idx = idx;
        last_b2b = (idx >= 0) ? int'(sh_tim[idx][31:24]) : 0;
    endtask

    task automatic rand_config();
        for (int i = 0; i < 8; i++) begin
            wr_cfg(0, i, mk_dec({12'h0, 4'($urandom_range(0, 15))}, 4'($urandom_range(0, 2)),
                                2'($urandom_range(0, 3)), ($urandom_range(0, 99) < 85),
                                ($urandom_range(0, 99) < 85)));
            wr_cfg(1, i, mk_tim(8'($urandom_range(0, 5)), 8'($urandom_range(0, 7)),
                                8'($urandom_range(0, 6)), 8'($urandom_range(0, 4))));
            wr_cfg(2, i, mk_pin(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                8'($urandom_range(0, 255)) & 8'h33, 8'($urandom_range(0, 255))));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin
            sh_dec[i] = '0;
            sh_tim[i] = '0;
            sh_pin[i] = '0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(strobe_n, 8'hFF, "R1 reset strobes");
        chk({7'b0, ready}, 8'h00, "R1 reset ready");
        chk({6'b0, data_width}, 8'h00, "R1 reset width");
        txn(24'h001000, 1'b0, "R1 R6 zero config");
        idle(1);

        // R2: program region 0 and four pins through the write port
        wr_cfg(0, 0, mk_dec(16'h0010, 4'd0, 2'd2, 1'b1, 1'b1));
        wr_cfg(1, 0, mk_tim(8'd1, 8'd3, 8'd4, 8'd0));
        wr_cfg(2, 0, mk_pin(3'd0, 2'b11, 1'b1, 1'b0, 8'h00, 8'h00));
        wr_cfg(2, 1, mk_pin(3'd0, 2'b01, 1'b0, 1'b0, 8'h00, 8'h00));
        wr_cfg(2, 2, mk_pin(3'd0, 2'b10, 1'b0, 1'b0, 8'h00, 8'h00));
        wr_cfg(2, 3, mk_pin(3'd0, 2'b11, 1'b0, 1'b1, 8'hF0, 8'h50));
        txn({16'h0010, 8'h5A}, 1'b0, "R2 R7 R8 R9 R10 read hit");
        idle(1);
        txn({16'h0010, 8'h6A}, 1'b1, "R9 R10 write sub miss");
        idle(1);
        wr_cfg(1, 0, mk_tim(8'd3, 8'd3, 8'd5, 8'd0));
        txn({16'h0010, 8'h00}, 1'b0, "R8 empty window");
        idle(1);
        wr_cfg(1, 0, mk_tim(8'd2, 8'd9, 8'd4, 8'd0));
        txn({16'h0010, 8'h00}, 1'b1, "R8 clipped by ready");
        idle(1);
        wr_cfg(1, 0, mk_tim(8'd0, 8'd1, 8'd0, 8'd0));
        txn({16'h0010, 8'h00}, 1'b0, "R5 R8 zero delay");
        idle(1);

        // R3 R4: overlapping region 1
        wr_cfg(0, 1, mk_dec(16'h0010, 4'd4, 2'd1, 1'b1, 1'b1));
        wr_cfg(1, 1, mk_tim(8'd0, 8'd2, 8'd3, 8'd0));
        wr_cfg(2, 4, mk_pin(3'd1, 2'b11, 1'b0, 1'b0, 8'h00, 8'h00));
        txn({16'h001F, 8'h00}, 1'b0, "R3 size top");
        idle(1);
        txn({16'h0010, 8'h00}, 1'b0, "R4 priority");
        idle(1);
        wr_cfg(0, 0, mk_dec(16'h0010, 4'd0, 2'd2, 1'b0, 1'b1));
        txn({16'h0010, 8'h00}, 1'b0, "R3 R4 read disabled");
        idle(1);
        txn({16'h0010, 8'h00}, 1'b1, "R3 R4 write enabled");
        idle(1);

        // R3 R11: region 2 with a recovery gap
        wr_cfg(0, 2, mk_dec(16'h0020, 4'd3, 2'd3, 1'b1, 1'b1));
        wr_cfg(1, 2, mk_tim(8'd0, 8'd1, 8'd2, 8'd5));
        wr_cfg(2, 5, mk_pin(3'd2, 2'b11, 1'b0, 1'b0, 8'h00, 8'h00));
        txn({16'h0027, 8'h00}, 1'b0, "R3 upper edge");
        idle(6);
        txn({16'h0028, 8'h00}, 1'b0, "R3 R6 outside");
        idle(1);
        txn({16'h0020, 8'h00}, 1'b0, "R11 first");
        idle(1);
        txn({16'h0023, 8'h00}, 1'b1, "R11 stall early");
        idle(1);
        txn({16'h0010, 8'h00}, 1'b1, "R11 other region no stall");
        idle(1);
        txn({16'h0020, 8'h00}, 1'b0, "R11 prime");
        idle(5);
        txn({16'h0021, 8'h00}, 1'b0, "R11 last gap cycle");
        idle(6);
        txn({16'h0022, 8'h00}, 1'b0, "R11 after gap");
        idle(1);

        for (int r = 0; r < 5; r++) begin
            rand_config();
            for (int t = 0; t < 40; t++) begin
                txn({12'h000, 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255))},
                    1'($urandom_range(0, 1)), "RND R3 R4 R5 R11");
                idle(1 + int'($urandom_range(0, 6)));
            end
            idle(6);
        end
        summary();
    end
endmodule